// File: doc/BRIEF.md
# Split-Screen Display Address Sequencer

This block supplies the memory row address for every display line of an LCD refresh engine, so that two independent images can share one frame. Software loads two image base addresses, a line pitch, a panel height, a top-region line count and a panel mode through a small byte-wide register port with 4-bit indices. The refresh engine gives one pulse at the start of each frame and one pulse per line. The block answers with the row address of the current line.

In single-panel mode the upper part of the screen comes from the first image. After the programmed number of lines the address reloads from the second base, and the rest of the panel comes from the second image. If the top region covers the whole panel, the second image is never reached. In dual-panel mode the line count plays no part. Two addresses are produced together: the upper half-panel reads the first image and the lower half-panel reads the second, each for half the panel height.

All register writes go to live copies. A frame pulse copies them into shadow copies that drive the sequencing, so a frame already in progress is never torn by a write.

Top module: `split_addr_seq`

## Requirements
- R1: After reset, row_addr_a, row_addr_b, row_valid, img_second and every register read return zero.
- R2: The register map is: indices 6/7 hold the first base (low/high byte), 8/9 the second base, 10 the low 8 bits of the 10-bit top count, 11 bits 1:0 its upper bits, 12 the 8-bit line pitch, 13 the low 8 bits of the 10-bit panel height, and 14 bits 1:0 the height's upper bits with bit 7 selecting dual-panel mode. Unused bits and unmapped indices read as zero.
- R3: One cycle after frame_start, row_addr_a equals the first base, row_addr_b equals the second base, img_second is 0, and row_valid is 1 when the active line count is nonzero.
- R4: Each line_strobe while row_valid is high advances the current row address by the pitch, modulo 2^16.
- R5: In single-panel mode with top count C, lines 0..C come from the first image. Line C+1 takes the second base exactly, with img_second set, and later lines add the pitch from there. For C = 20h on a 240-line panel, this gives 33 lines from the first image and 207 from the second.
- R6: In single-panel mode, when C+1 is at least the panel height, every line of the frame comes from the first image and img_second stays 0.
- R7: In dual-panel mode the top count is ignored. row_addr_a and row_addr_b advance together from the first and second bases, for panel height / 2 lines.
- R8: A register write made during a frame does not change that frame's sequence. It takes effect at the next frame_start.
- R9: The strobe that would pass the last active line clears row_valid. After that, the addresses hold and further strobes have no effect until the next frame_start.
- R10: When frame_start and line_strobe are high in the same cycle, frame_start wins and line 0 of a new frame is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_idx (combinational) |
| frame_start | input | 1 | Frame pulse: latches the shadow copies and restarts sequencing |
| line_strobe | input | 1 | Advance to the next display line |
| row_addr_a | output | 16 | Row address in single-panel mode, or upper half-panel address in dual mode |
| row_addr_b | output | 16 | Lower half-panel row address in dual mode |
| row_valid | output | 1 | The current line is inside the active frame |
| img_second | output | 1 | In single-panel mode, the current line comes from the second image |

## Verification
A wrong line counter moves the image switch: row_addr_a jumps to the second base one strobe too early or too late, and img_second rises on that same wrong line, visible one cycle after the strobe. A wrong accumulator or pitch shows on the very next strobe as an address that misses the expected base + k·pitch value. A shadow that follows live writes shows up later, at the switch line of a frame in which the count was rewritten. A bad active-line limit shows at the end of the frame, where row_valid drops on the wrong strobe.

// File: rtl/sas_pkg.sv
package sas_pkg;
  localparam int ADDR_W  = 16;
  localparam int CNT_W   = 10;
  localparam int PITCH_W = 8;
  localparam int DATA_W  = 8;
  localparam int RIDX_W  = 4;
  localparam int LANES   = 2;
  localparam int IDX_W   = CNT_W + 1;
  localparam int DUAL_BIT = 7;

  localparam logic [RIDX_W-1:0] IDX_B1_LO  = 4'h6;
  localparam logic [RIDX_W-1:0] IDX_B1_HI  = 4'h7;
  localparam logic [RIDX_W-1:0] IDX_B2_LO  = 4'h8;
  localparam logic [RIDX_W-1:0] IDX_B2_HI  = 4'h9;
  localparam logic [RIDX_W-1:0] IDX_TOP_LO = 4'hA;
  localparam logic [RIDX_W-1:0] IDX_TOP_HI = 4'hB;
  localparam logic [RIDX_W-1:0] IDX_PITCH  = 4'hC;
  localparam logic [RIDX_W-1:0] IDX_HT_LO  = 4'hD;
  localparam logic [RIDX_W-1:0] IDX_HT_HI  = 4'hE;

  typedef struct packed {
    logic [ADDR_W-1:0]  first_base;
    logic [ADDR_W-1:0]  second_base;
    logic [CNT_W-1:0]   top_lines;
    logic [CNT_W-1:0]   panel_h;
    logic [PITCH_W-1:0] pitch;
    logic               dual;
  } seq_cfg_t;
endpackage

// File: rtl/sas_regs.sv
module sas_regs
  import sas_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [RIDX_W-1:0]   reg_idx,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                frame_start,
  output logic [ADDR_W-1:0]   live_first,
  output logic [ADDR_W-1:0]   live_second,
  output logic [CNT_W-1:0]    live_panel_h,
  output logic                live_dual,
  output logic [ADDR_W-1:0]   sh_second,
  output logic [CNT_W-1:0]    sh_top_lines,
  output logic [CNT_W-1:0]    sh_panel_h,
  output logic [PITCH_W-1:0]  sh_pitch,
  output logic                sh_dual
);
  localparam int HI_W = CNT_W - DATA_W;

  seq_cfg_t live_q, live_d;
  seq_cfg_t shad_q, shad_d;

  // Write decode into live copies
  always_comb begin
    live_d = live_q;
    if (reg_we) begin
      case (reg_idx)
        IDX_B1_LO:  live_d.first_base[DATA_W-1:0]         = reg_wdata;
        IDX_B1_HI:  live_d.first_base[ADDR_W-1:DATA_W]    = reg_wdata;
        IDX_B2_LO:  live_d.second_base[DATA_W-1:0]        = reg_wdata;
        IDX_B2_HI:  live_d.second_base[ADDR_W-1:DATA_W]   = reg_wdata;
        IDX_TOP_LO: live_d.top_lines[DATA_W-1:0]          = reg_wdata;
        IDX_TOP_HI: live_d.top_lines[CNT_W-1:DATA_W]      = reg_wdata[HI_W-1:0];
        IDX_PITCH:  live_d.pitch                          = reg_wdata;
        IDX_HT_LO:  live_d.panel_h[DATA_W-1:0]            = reg_wdata;
        IDX_HT_HI: begin
          live_d.panel_h[CNT_W-1:DATA_W] = reg_wdata[HI_W-1:0];
          live_d.dual                    = reg_wdata[DUAL_BIT];
        end
        default: ;
      endcase
    end
  end

  // Shadow copies follow the live copies only at a frame boundary
  always_comb begin
    shad_d = shad_q;
    if (frame_start) begin
      shad_d = live_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      shad_q <= '0;
    end else begin
      live_q <= live_d;
      shad_q <= shad_d;
    end
  end

  // Read mux, unused bits and indices return zero
  always_comb begin
    reg_rdata = '0;
    case (reg_idx)
      IDX_B1_LO:  reg_rdata = live_q.first_base[DATA_W-1:0];
      IDX_B1_HI:  reg_rdata = live_q.first_base[ADDR_W-1:DATA_W];
      IDX_B2_LO:  reg_rdata = live_q.second_base[DATA_W-1:0];
      IDX_B2_HI:  reg_rdata = live_q.second_base[ADDR_W-1:DATA_W];
      IDX_TOP_LO: reg_rdata = live_q.top_lines[DATA_W-1:0];
      IDX_TOP_HI: reg_rdata = {{(DATA_W-HI_W){1'b0}}, live_q.top_lines[CNT_W-1:DATA_W]};
      IDX_PITCH:  reg_rdata = live_q.pitch;
      IDX_HT_LO:  reg_rdata = live_q.panel_h[DATA_W-1:0];
      IDX_HT_HI:  reg_rdata = {live_q.dual, {(DATA_W-HI_W-1){1'b0}},
                               live_q.panel_h[CNT_W-1:DATA_W]};
      default:    reg_rdata = '0;
    endcase
  end

  assign live_first   = live_q.first_base;
  assign live_second  = live_q.second_base;
  assign live_panel_h = live_q.panel_h;
  assign live_dual    = live_q.dual;
  assign sh_second    = shad_q.second_base;
  assign sh_top_lines = shad_q.top_lines;
  assign sh_panel_h   = shad_q.panel_h;
  assign sh_pitch     = shad_q.pitch;
  assign sh_dual      = shad_q.dual;

  AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(shad_q)); // R8
  AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (sh_top_lines == $past(live_q.top_lines))); // R8
  AST_TOP_HI_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx == IDX_TOP_HI) |-> (reg_rdata[DATA_W-1:HI_W] == '0)); // R2
endmodule

// File: rtl/sas_line_ctrl.sv
module sas_line_ctrl
  import sas_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             line_strobe,
  input  logic [CNT_W-1:0] live_panel_h,
  input  logic             live_dual,
  input  logic [CNT_W-1:0] sh_top_lines,
  input  logic [CNT_W-1:0] sh_panel_h,
  input  logic             sh_dual,
  output logic             line_valid,
  output logic             img_second,
  output logic             advance,
  output logic             switch_now
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             valid_q, valid_d;
  logic             sel_q, sel_d;
  logic [IDX_W-1:0] idx_inc;
  logic [IDX_W-1:0] act_sh;
  logic [IDX_W-1:0] act_live;
  logic [IDX_W-1:0] switch_line;

  function automatic logic [IDX_W-1:0] active_lines(input logic [CNT_W-1:0] h,
                                                    input logic d);
    if (d) return {2'b00, h[CNT_W-1:1]};
    return {1'b0, h};
  endfunction

  assign act_sh      = active_lines(sh_panel_h, sh_dual);
  assign act_live    = active_lines(live_panel_h, live_dual);
  assign idx_inc     = idx_q + IDX_W'(1);
  assign switch_line = {1'b0, sh_top_lines} + IDX_W'(1);

  always_comb begin
    idx_d      = idx_q;
    valid_d    = valid_q;
    sel_d      = sel_q;
    advance    = 1'b0;
    switch_now = 1'b0;
    if (frame_start) begin
      idx_d   = '0;
      valid_d = (act_live != '0);
      sel_d   = 1'b0;
    end else if (line_strobe && valid_q) begin
      idx_d = idx_inc;
      if (idx_inc >= act_sh) begin
        valid_d = 1'b0;
      end else begin
        advance = 1'b1;
        if (!sh_dual && (idx_inc == switch_line)) begin
          switch_now = 1'b1;
          sel_d      = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      valid_q <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      valid_q <= valid_d;
      sel_q   <= sel_d;
    end
  end

  assign line_valid = valid_q;
  assign img_second = sel_q;

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= act_sh); // R9
  AST_SWITCH_AT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_q) |-> (idx_q == switch_line)); // R5
  AST_DUAL_NO_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    sh_dual |-> !switch_now); // R7
  AST_SEL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && !frame_start) |=> sel_q); // R5
  AST_FRAME_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (idx_q == '0 && !sel_q)); // R10
  AST_INVALID_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_q && !frame_start) |=> !valid_q); // R9
endmodule

// File: rtl/sas_addr_acc.sv
module sas_addr_acc #(
  parameter int W      = 16,
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [W-1:0]      load_val,
  input  logic              add,
  input  logic [STEP_W-1:0] step,
  output logic [W-1:0]      acc
);
  logic [W-1:0] acc_q, acc_d;

  always_comb begin
    acc_d = acc_q;
    if (load) begin
      acc_d = load_val;
    end else if (add) begin
      acc_d = acc_q + W'(step);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  assign acc = acc_q;

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (acc_q == $past(load_val))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !add) |=> $stable(acc_q)); // R9
endmodule

// File: rtl/split_addr_seq.sv
module split_addr_seq
  import sas_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [RIDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               frame_start,
  input  logic               line_strobe,
  output logic [ADDR_W-1:0]  row_addr_a,
  output logic [ADDR_W-1:0]  row_addr_b,
  output logic               row_valid,
  output logic               img_second
);
  logic rst_meta_n, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [ADDR_W-1:0]  live_first, live_second, sh_second;
  logic [CNT_W-1:0]   live_panel_h, sh_top_lines, sh_panel_h;
  logic [PITCH_W-1:0] sh_pitch;
  logic               live_dual, sh_dual;
  logic               advance, switch_now;

  sas_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .reg_we       (reg_we),
    .reg_idx      (reg_idx),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .frame_start  (frame_start),
    .live_first   (live_first),
    .live_second  (live_second),
    .live_panel_h (live_panel_h),
    .live_dual    (live_dual),
    .sh_second    (sh_second),
    .sh_top_lines (sh_top_lines),
    .sh_panel_h   (sh_panel_h),
    .sh_pitch     (sh_pitch),
    .sh_dual      (sh_dual)
  );

  sas_line_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .frame_start  (frame_start),
    .line_strobe  (line_strobe),
    .live_panel_h (live_panel_h),
    .live_dual    (live_dual),
    .sh_top_lines (sh_top_lines),
    .sh_panel_h   (sh_panel_h),
    .sh_dual      (sh_dual),
    .line_valid   (row_valid),
    .img_second   (img_second),
    .advance      (advance),
    .switch_now   (switch_now)
  );

  // Lane 0 feeds the single panel or upper half, lane 1 the lower half
  logic [LANES-1:0]  lane_load, lane_add;
  logic [ADDR_W-1:0] lane_val [LANES];
  logic [ADDR_W-1:0] lane_acc [LANES];

  always_comb begin
    lane_load[0] = frame_start | switch_now;
    lane_val[0]  = frame_start ? live_first : sh_second;
    lane_add[0]  = advance & ~switch_now;
    lane_load[1] = frame_start;
    lane_val[1]  = live_second;
    lane_add[1]  = advance;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sas_addr_acc #(.W(ADDR_W), .STEP_W(PITCH_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .load     (lane_load[g]),
      .load_val (lane_val[g]),
      .add      (lane_add[g]),
      .step     (sh_pitch),
      .acc      (lane_acc[g])
    );
  end

  assign row_addr_a = lane_acc[0];
  assign row_addr_b = lane_acc[1];

  AST_STEP_BY_PITCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (line_strobe && row_valid && !frame_start && !img_second && row_valid)
      |=> (!row_valid || img_second || row_addr_a == $past(row_addr_a) + ADDR_W'(sh_pitch))); // R4
  AST_SWITCH_BASE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(img_second) |-> (row_addr_a == sh_second)); // R5
  AST_FRAME_BASES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_start |=> (row_addr_a == $past(live_first) && row_addr_b == $past(live_second))); // R3
endmodule

// File: tb/split_addr_seq_tb_top.sv
`timescale 1ns/1ps
module split_addr_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [3:0]  reg_idx;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        frame_start, line_strobe;
  logic [15:0] row_addr_a, row_addr_b;
  logic        row_valid, img_second;

  always #2 clk = ~clk;

  split_addr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
    .line_strobe(line_strobe), .row_addr_a(row_addr_a), .row_addr_b(row_addr_b),
    .row_valid(row_valid), .img_second(img_second)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Checkpoints for base1=1000h, base2=8000h, pitch=28h, count=20h, 240 lines
  // [31] expected img_second, [27:16] line number, [15:0] expected row_addr_a
  localparam logic [31:0] CKPT [8] = '{
    {1'b0, 3'b0, 12'd0,   16'h1000},
    {1'b0, 3'b0, 12'd1,   16'h1028},
    {1'b0, 3'b0, 12'd32,  16'h1500},
    {1'b1, 3'b0, 12'd33,  16'h8000},
    {1'b1, 3'b0, 12'd34,  16'h8028},
    {1'b1, 3'b0, 12'd100, 16'h8A78},
    {1'b1, 3'b0, 12'd200, 16'h9A18},
    {1'b1, 3'b0, 12'd239, 16'hA030}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [7:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = idx; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [7:0] data);
    @(negedge clk);
    reg_idx = idx;
    #1 data = reg_rdata;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic pulse_line();
    @(negedge clk); line_strobe = 1'b1;
    @(negedge clk); line_strobe = 1'b0;
  endtask

  task automatic prog(input logic [15:0] b1, input logic [15:0] b2, input logic [9:0] cnt,
                      input logic [7:0] pitch, input logic [9:0] ht, input logic dual);
    wr(4'h6, b1[7:0]);  wr(4'h7, b1[15:8]);
    wr(4'h8, b2[7:0]);  wr(4'h9, b2[15:8]);
    wr(4'hA, cnt[7:0]); wr(4'hB, {6'b0, cnt[9:8]});
    wr(4'hC, pitch);
    wr(4'hD, ht[7:0]);  wr(4'hE, {dual, 5'b0, ht[9:8]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    int n_first, n_second;
    rst_n = 1'b0; reg_we = 1'b0; reg_idx = '0; reg_wdata = '0;
    frame_start = 1'b0; line_strobe = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 row_addr_a", row_addr_a, 0);
    chk("R1 row_addr_b", row_addr_b, 0);
    chk("R1 row_valid", row_valid, 0);
    chk("R1 img_second", img_second, 0);
    rd(4'hA, rv); chk("R1 count reg", rv, 0);

    // R2: register map and padding
    prog(16'h1000, 16'h8000, 10'h3FF, 8'h28, 10'd240, 1'b0);
    rd(4'h7, rv); chk("R2 base1 hi", rv, 8'h10);
    rd(4'h8, rv); chk("R2 base2 lo", rv, 8'h00);
    rd(4'h9, rv); chk("R2 base2 hi", rv, 8'h80);
    wr(4'hB, 8'hFF);
    rd(4'hB, rv); chk("R2 count hi pad", rv, 8'h03);
    rd(4'hC, rv); chk("R2 pitch", rv, 8'h28);
    rd(4'hD, rv); chk("R2 height lo", rv, 8'hF0);
    wr(4'h3, 8'h55);
    rd(4'h3, rv); chk("R2 unmapped", rv, 8'h00);
    wr(4'hE, 8'h80);
    rd(4'hE, rv); chk("R2 mode bit", rv, 8'h80);
    wr(4'hE, 8'h00);
    wr(4'hA, 8'h20); wr(4'hB, 8'h00);
    rd(4'hA, rv); chk("R2 count lo", rv, 8'h20);

    // R3, R4, R5, R8: single-panel table walk
    pulse_frame();
    chk("R3 valid after frame", row_valid, 1);
    chk("R3 row_addr_b base2", row_addr_b, 16'h8000);
    n_first = 0; n_second = 0;
    for (int line = 0; line < 240; line++) begin
      if (line > 0) pulse_line();
      if (line == 10) wr(4'hA, 8'h05); // R8: mid-frame rewrite must not move the switch
      if (img_second) n_second++; else n_first++;
      for (int k = 0; k < 8; k++) begin
        if (CKPT[k][27:16] == 12'(line)) begin
          chk("R5/R4 row_addr_a", row_addr_a, CKPT[k][15:0]);
          chk("R5 img_second", img_second, CKPT[k][31]);
        end
      end
    end
    chk("R5 first-image lines", n_first, 33);
    chk("R5 second-image lines", n_second, 207);
    chk("R8 valid at last line", row_valid, 1);

    // R9: past the end
    pulse_line();
    chk("R9 valid drops", row_valid, 0);
    chk("R9 addr holds", row_addr_a, 16'hA030);
    pulse_line();
    chk("R9 strobe ignored", row_addr_a, 16'hA030);

    // R8: the rewritten count (5) now takes effect
    pulse_frame();
    repeat (6) pulse_line();
    chk("R8 switch at line 6", row_addr_a, 16'h8000);
    chk("R8 img_second", img_second, 1);

    // R6: count covers the panel
    wr(4'hA, 8'hEF);
    pulse_frame();
    repeat (239) pulse_line();
    chk("R6 last line addr", row_addr_a, 16'h3558);
    chk("R6 never second", img_second, 0);
    chk("R6 still valid", row_valid, 1);
    wr(4'hA, 8'hFF); wr(4'hB, 8'h03);
    pulse_frame();
    repeat (239) pulse_line();
    chk("R6 max count", img_second, 0);

    // R7: dual-panel mode with small count
    wr(4'hA, 8'h05); wr(4'hB, 8'h00);
    wr(4'hE, 8'h80);
    pulse_frame();
    chk("R7 upper base", row_addr_a, 16'h1000);
    chk("R7 lower base", row_addr_b, 16'h8000);
    repeat (119) pulse_line();
    chk("R7 upper line119", row_addr_a, 16'h2298);
    chk("R7 lower line119", row_addr_b, 16'h9298);
    chk("R7 no switch", img_second, 0);
    chk("R7 valid line119", row_valid, 1);
    pulse_line();
    chk("R7 half height end", row_valid, 0);

    // R10: frame and line together
    wr(4'hE, 8'h00);
    pulse_frame();
    repeat (3) pulse_line();
    @(negedge clk); frame_start = 1'b1; line_strobe = 1'b1;
    @(negedge clk); frame_start = 1'b0; line_strobe = 1'b0;
    chk("R10 frame wins", row_addr_a, 16'h1000);

    // R4: wrap modulo 2^16
    wr(4'h6, 8'hF0); wr(4'h7, 8'hFF);
    pulse_frame();
    pulse_line();
    chk("R4 wrap", row_addr_a, 16'h0018);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule